// File: doc/BRIEF.md
# Four-Channel DMA Programming Register Bank

This block holds everything software programs into a four-channel DMA controller before a transfer starts. For each channel it keeps a 16-bit start address, a 16-bit transfer count, a mode field and an 8-bit page value that supplies address bits 23:16. Each address and count has a base copy and a current copy. For the whole controller it keeps a mask bit per channel, a command byte and a status byte. Software reaches all of it through byte-wide ports. Because the address and count registers are 16 bits wide, one shared byte pointer steers successive accesses to the low byte and then to the high byte.

The transfer engine connects through pulse inputs and level outputs. The pulse inputs raise or drop request flags and latch terminal-count flags in the status byte. The level outputs give the engine the mask, command, mode, page, base and current values. Several ports act on more than plain storage. Reading status clears the terminal-count flags. Dedicated command ports reset the byte pointer, edit the masks, or perform a master clear.

Top module: `dmac_regbank`

## Requirements
- R1: After reset all four mask bits are 1. The byte pointer selects the low byte. Status, command, modes, addresses, counts and pages are all zero.
- R2: The byte pointer selects the low byte when clear and the high byte when set. Every read or write of ports 0x00 to 0x07 inverts it. A write to port 0x0C clears it.
- R3: Port 0x00 to 0x07 selects channel port>>1. Even ports select the channel's address register and odd ports select its count register.
- R4: A write to an address or count port updates the base and current copies together. A low-byte write replaces the whole 16-bit value with the zero-extended data byte. A high-byte write ORs the data byte into bits 15:8 and keeps bits 7:0.
- R5: rd_data shows the result of a read in the cycle after rd_en and is 0x00 in every other cycle. A read of an address or count port returns the low or high byte of the current copy, chosen by the byte pointer.
- R6: The status byte holds request flags for channels 3..0 in bits 7:4 and terminal-count flags for channels 3..0 in bits 3:0. A read of port 0x08 returns the whole byte and then clears bits 3:0. A tc_set pulse arriving in the same cycle as that read wins, and its flag stays set. req_set raises request flags and req_clr drops them.
- R7: A write to port 0x0A uses data bits 1:0 as the channel. Data bit 2 sets that channel's mask when 1 and clears it when 0. The other masks do not change.
- R8: A write to port 0x0F loads mask bits 3..0 from data bits 3..0. Any write to port 0x0E clears all four masks.
- R9: A write to port 0x0B selects the channel with data bits 1:0 and stores that channel's mode as 6 bits in mode_o. From msb to lsb these are: transfer mode (data 7:6, where 0 is demand, 1 single, 2 block, 3 cascade), decrement (data 5), auto-reload (data 4), and transfer direction (data 3:2).
- R10: Any write to port 0x0D sets all masks and clears the command, status and byte pointer. Addresses, counts, pages and modes are kept.
- R11: Page ports 0x87, 0x83, 0x81 and 0x82 belong to channels 0, 1, 2 and 3. Each can be written and read back.
- R12: A write to port 0x09 with data bit 2 clear drops the request flag of the channel in data bits 1:0. With bit 2 set the write changes nothing.
- R13: A write to port 0x08 loads the command byte shown on cmd_o.
- R14: A read of any port not named above returns 0x00. This includes the write-only ports 0x09 to 0x0F. A write to a port not named above changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_addr | input | 8 | Port number of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| req_set | input | 4 | Raise request flags, one per channel |
| req_clr | input | 4 | Drop request flags, one per channel |
| tc_set | input | 4 | Latch terminal-count flags, one per channel |
| mask_o | output | 4 | Channel mask bits |
| cmd_o | output | 8 | Command byte |
| mode_o | output | 24 | Channel modes, 6 bits per channel, channel 0 lowest |
| page_o | output | 32 | Page values, 8 bits per channel |
| base_addr_o | output | 64 | Base address, 16 bits per channel |
| cur_addr_o | output | 64 | Current address, 16 bits per channel |
| base_cnt_o | output | 64 | Base count, 16 bits per channel |
| cur_cnt_o | output | 64 | Current count, 16 bits per channel |

## Verification
The bench builds the block with its default 8-bit data width. That default gives 16-bit address and count registers, so every two-byte sequence the shared pointer drives can be reached, including the case where a stray read leaves the pointer on the high byte and the next write ORs instead of replacing. Four channels and an 8-bit port number put every page port and every unmapped neighbour within reach. This lets the bench cover the decode boundaries and the same-cycle race between a status read and a terminal-count pulse.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);

  typedef struct packed {
    logic [1:0] kind;     // 0 demand, 1 single, 2 block, 3 cascade
    logic       down;     // address decrement
    logic       auto_ld;  // auto-reload at end of count
    logic [1:0] xfer;     // transfer direction
  } chan_mode_t;

  localparam int MODE_W = $bits(chan_mode_t);

  localparam logic [7:0] P_STAT    = 8'h08;
  localparam logic [7:0] P_REQ     = 8'h09;
  localparam logic [7:0] P_MASK1   = 8'h0A;
  localparam logic [7:0] P_MODE    = 8'h0B;
  localparam logic [7:0] P_PTRCLR  = 8'h0C;
  localparam logic [7:0] P_MCLR    = 8'h0D;
  localparam logic [7:0] P_MASKCLR = 8'h0E;
  localparam logic [7:0] P_MASKALL = 8'h0F;

  function automatic logic [7:0] page_port(input int ch);
    case (ch)
      0:       return 8'h87;
      1:       return 8'h83;
      2:       return 8'h81;
      default: return 8'h82;
    endcase
  endfunction
endpackage

// File: rtl/dmac_port_decode.sv
module dmac_port_decode
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] port_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              ac_hit,
  output logic              ac_is_cnt,
  output logic [CH_W-1:0]   ac_ch,
  output logic              ac_access,
  output logic              wr_cmd,
  output logic              wr_req,
  output logic              wr_mask1,
  output logic              wr_mode,
  output logic              wr_ptrclr,
  output logic              wr_mclr,
  output logic              wr_maskclr,
  output logic              wr_maskall,
  output logic              rd_stat,
  output logic [NUM_CH-1:0] page_hit
);
  localparam int AC_BITS = CH_W + 1;

  assign ac_hit    = (port_addr >> AC_BITS) == '0;
  assign ac_is_cnt = port_addr[0];
  assign ac_ch     = port_addr[AC_BITS-1:1];
  assign ac_access = ac_hit && (wr_en || rd_en);

  assign wr_cmd     = wr_en && (port_addr == ADDR_W'(P_STAT));
  assign wr_req     = wr_en && (port_addr == ADDR_W'(P_REQ));
  assign wr_mask1   = wr_en && (port_addr == ADDR_W'(P_MASK1));
  assign wr_mode    = wr_en && (port_addr == ADDR_W'(P_MODE));
  assign wr_ptrclr  = wr_en && (port_addr == ADDR_W'(P_PTRCLR));
  assign wr_mclr    = wr_en && (port_addr == ADDR_W'(P_MCLR));
  assign wr_maskclr = wr_en && (port_addr == ADDR_W'(P_MASKCLR));
  assign wr_maskall = wr_en && (port_addr == ADDR_W'(P_MASKALL));
  assign rd_stat    = rd_en && (port_addr == ADDR_W'(P_STAT));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_page
    assign page_hit[i] = (port_addr == ADDR_W'(page_port(i)));
  end
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8,
  localparam int REG_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_addr,
  input  logic              ld_cnt,
  input  logic              hi_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mode_we,
  input  chan_mode_t        mode_in,
  input  logic              page_we,
  output logic [REG_W-1:0]  base_addr,
  output logic [REG_W-1:0]  cur_addr,
  output logic [REG_W-1:0]  base_cnt,
  output logic [REG_W-1:0]  cur_cnt,
  output chan_mode_t        mode,
  output logic [PAGE_W-1:0] page
);
  function automatic logic [REG_W-1:0] merge(input logic [REG_W-1:0] old,
                                             input logic hi,
                                             input logic [DATA_W-1:0] d);
    logic [REG_W-1:0] r;
    if (!hi) r = REG_W'(d);
    else     r = {old[REG_W-1:DATA_W] | d, old[DATA_W-1:0]};
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      cur_addr  <= '0;
      base_cnt  <= '0;
      cur_cnt   <= '0;
      mode      <= '0;
      page      <= '0;
    end else begin
      if (ld_addr) begin
        base_addr <= merge(base_addr, hi_sel, wr_data);
        cur_addr  <= merge(cur_addr, hi_sel, wr_data);
      end
      if (ld_cnt) begin
        base_cnt <= merge(base_cnt, hi_sel, wr_data);
        cur_cnt  <= merge(cur_cnt, hi_sel, wr_data);
      end
      if (mode_we) mode <= mode_in;
      if (page_we) page <= PAGE_W'(wr_data);
    end
  end
endmodule

// File: rtl/dmac_ctl_regs.sv
module dmac_ctl_regs
  import dmac_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ac_access,
  input  logic              wr_cmd,
  input  logic              wr_req,
  input  logic              wr_mask1,
  input  logic              wr_ptrclr,
  input  logic              wr_mclr,
  input  logic              wr_maskclr,
  input  logic              wr_maskall,
  input  logic              rd_stat,
  input  logic [NUM_CH-1:0] req_set,
  input  logic [NUM_CH-1:0] req_clr,
  input  logic [NUM_CH-1:0] tc_set,
  output logic              hi_sel,
  output logic [NUM_CH-1:0] mask,
  output logic [DATA_W-1:0] cmd,
  output logic [2*NUM_CH-1:0] status
);
  logic [NUM_CH-1:0] req_q, tc_q, req_d, tc_d, req_drop, mask_d;

  always_comb begin
    req_drop = req_clr;
    if (wr_req && !wr_data[2]) req_drop[wr_data[CH_W-1:0]] = 1'b1;
    req_d = (req_q & ~req_drop) | req_set;
    tc_d  = (rd_stat ? '0 : tc_q) | tc_set;

    mask_d = mask;
    if (wr_mask1)   mask_d[wr_data[CH_W-1:0]] = wr_data[2];
    if (wr_maskall) mask_d = wr_data[NUM_CH-1:0];
    if (wr_maskclr) mask_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || wr_mclr) begin
      hi_sel <= 1'b0;
      mask   <= '1;
      cmd    <= '0;
      req_q  <= '0;
      tc_q   <= '0;
    end else begin
      if (wr_ptrclr)      hi_sel <= 1'b0;
      else if (ac_access) hi_sel <= ~hi_sel;
      mask  <= mask_d;
      req_q <= req_d;
      tc_q  <= tc_d;
      if (wr_cmd) cmd <= wr_data;
    end
  end

  assign status = {req_q, tc_q};
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8,
  localparam int REG_W = 2 * DATA_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          port_addr,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  output logic [DATA_W-1:0]          rd_data,
  input  logic [NUM_CH-1:0]          req_set,
  input  logic [NUM_CH-1:0]          req_clr,
  input  logic [NUM_CH-1:0]          tc_set,
  output logic [NUM_CH-1:0]          mask_o,
  output logic [DATA_W-1:0]          cmd_o,
  output logic [NUM_CH*MODE_W-1:0]   mode_o,
  output logic [NUM_CH*PAGE_W-1:0]   page_o,
  output logic [NUM_CH*REG_W-1:0]    base_addr_o,
  output logic [NUM_CH*REG_W-1:0]    cur_addr_o,
  output logic [NUM_CH*REG_W-1:0]    base_cnt_o,
  output logic [NUM_CH*REG_W-1:0]    cur_cnt_o
);
  logic              ac_hit, ac_is_cnt, ac_access;
  logic [CH_W-1:0]   ac_ch;
  logic              wr_cmd, wr_req, wr_mask1, wr_mode, wr_ptrclr;
  logic              wr_mclr, wr_maskclr, wr_maskall, rd_stat;
  logic [NUM_CH-1:0] page_hit;
  logic              hi_sel;
  logic [2*NUM_CH-1:0] status_q;

  logic [REG_W-1:0]  cur_addr_a [NUM_CH];
  logic [REG_W-1:0]  cur_cnt_a  [NUM_CH];
  logic [PAGE_W-1:0] page_a     [NUM_CH];
  chan_mode_t        mode_in;

  dmac_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .port_addr (port_addr), .wr_en(wr_en), .rd_en(rd_en),
    .ac_hit    (ac_hit), .ac_is_cnt(ac_is_cnt), .ac_ch(ac_ch),
    .ac_access (ac_access), .wr_cmd(wr_cmd), .wr_req(wr_req),
    .wr_mask1  (wr_mask1), .wr_mode(wr_mode), .wr_ptrclr(wr_ptrclr),
    .wr_mclr   (wr_mclr), .wr_maskclr(wr_maskclr), .wr_maskall(wr_maskall),
    .rd_stat   (rd_stat), .page_hit(page_hit)
  );

  dmac_ctl_regs #(.DATA_W(DATA_W)) u_ctl (
    .clk       (clk), .rst(rst), .wr_data(wr_data), .ac_access(ac_access),
    .wr_cmd    (wr_cmd), .wr_req(wr_req), .wr_mask1(wr_mask1),
    .wr_ptrclr (wr_ptrclr), .wr_mclr(wr_mclr), .wr_maskclr(wr_maskclr),
    .wr_maskall(wr_maskall), .rd_stat(rd_stat), .req_set(req_set),
    .req_clr   (req_clr), .tc_set(tc_set), .hi_sel(hi_sel),
    .mask      (mask_o), .cmd(cmd_o), .status(status_q)
  );

  assign mode_in = chan_mode_t'({wr_data[7:6], wr_data[5], wr_data[4], wr_data[3:2]});

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic       sel;
    chan_mode_t mode_q;
    assign sel = wr_en && ac_hit && (ac_ch == CH_W'(i));

    dmac_chan_regs #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_chan (
      .clk       (clk), .rst(rst),
      .ld_addr   (sel && !ac_is_cnt),
      .ld_cnt    (sel && ac_is_cnt),
      .hi_sel    (hi_sel), .wr_data(wr_data),
      .mode_we   (wr_mode && (wr_data[CH_W-1:0] == CH_W'(i))),
      .mode_in   (mode_in),
      .page_we   (wr_en && page_hit[i]),
      .base_addr (base_addr_o[i*REG_W +: REG_W]),
      .cur_addr  (cur_addr_a[i]),
      .base_cnt  (base_cnt_o[i*REG_W +: REG_W]),
      .cur_cnt   (cur_cnt_a[i]),
      .mode      (mode_q),
      .page      (page_a[i])
    );

    assign cur_addr_o[i*REG_W +: REG_W]   = cur_addr_a[i];
    assign cur_cnt_o[i*REG_W +: REG_W]    = cur_cnt_a[i];
    assign page_o[i*PAGE_W +: PAGE_W]     = page_a[i];
    assign mode_o[i*MODE_W +: MODE_W]     = mode_q;
  end

  logic [DATA_W-1:0] rd_byte;
  logic [REG_W-1:0]  ac_val;

  always_comb begin
    ac_val  = ac_is_cnt ? cur_cnt_a[ac_ch] : cur_addr_a[ac_ch];
    rd_byte = '0;
    if (ac_hit)
      rd_byte = hi_sel ? ac_val[REG_W-1:DATA_W] : ac_val[DATA_W-1:0];
    else if (rd_stat)
      rd_byte = DATA_W'(status_q);
    else
      for (int i = 0; i < NUM_CH; i++)
        if (page_hit[i]) rd_byte = DATA_W'(page_a[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_byte;
    else            rd_data <= '0;
  end
endmodule

// File: rtl/dmac_regbank_chk.sv
module dmac_regbank_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] port_addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [3:0] tc_set,
  input logic [3:0] mask_o,
  input logic [7:0] status_q,
  input logic       hi_sel
);
  p_ptr_flip_r2: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && port_addr < 8'h08) |=> hi_sel != $past(hi_sel));

  p_ptr_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_addr == 8'h0C) |=> !hi_sel);

  p_rd_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == 8'h00);

  p_stat_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && port_addr == 8'h08 && tc_set == 4'h0) |=> status_q[3:0] == 4'h0);

  p_tc_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (tc_set != 4'h0 && !(wr_en && port_addr == 8'h0D))
      |=> (status_q[3:0] & $past(tc_set)) == $past(tc_set));

  p_mask_one_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_addr == 8'h0A) |=> mask_o[$past(wr_data[1:0])] == $past(wr_data[2]));

  p_mask_all_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_addr == 8'h0F) |=> mask_o == $past(wr_data[3:0]));

  p_mclr_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_addr == 8'h0D) |=> (mask_o == 4'hF && status_q == 8'h00 && !hi_sel));
endmodule

bind dmac_regbank dmac_regbank_chk u_chk (
  .clk(clk), .rst(rst), .port_addr(port_addr), .wr_en(wr_en), .rd_en(rd_en),
  .wr_data(wr_data), .rd_data(rd_data), .tc_set(tc_set), .mask_o(mask_o),
  .status_q(status_q), .hi_sel(hi_sel)
);

// File: tb/dmac_regbank_test.sv
module dmac_regbank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  port_addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [3:0]  req_set = '0, req_clr = '0, tc_set = '0;
  logic [3:0]  mask_o;
  logic [7:0]  cmd_o;
  logic [23:0] mode_o;
  logic [31:0] page_o;
  logic [63:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dmac_regbank uut (
    .clk(clk), .rst(rst), .port_addr(port_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .req_set(req_set), .req_clr(req_clr),
    .tc_set(tc_set), .mask_o(mask_o), .cmd_o(cmd_o), .mode_o(mode_o),
    .page_o(page_o), .base_addr_o(base_addr_o), .cur_addr_o(cur_addr_o),
    .base_cnt_o(base_cnt_o), .cur_cnt_o(cur_cnt_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); port_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); port_addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic pulse(input logic [3:0] rs, input logic [3:0] rc, input logic [3:0] tc);
    @(negedge clk); req_set = rs; req_clr = rc; tc_set = tc;
    @(negedge clk); req_set = '0; req_clr = '0; tc_set = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 masks", mask_o, 4'hF);
    chk("R1 cmd", cmd_o, 0);
    chk("R1 modes", mode_o, 0);
    chk("R1 pages", page_o, 0);
    chk("R1 addr", cur_addr_o, 0);
    chk("R5 rd idle", rd_data, 0);
    rd(8'h08, d); chk("R1 status", d, 0);
    wr(8'h02, 8'h5A);
    chk("R1 pointer low after reset", cur_addr_o[31:16], 16'h005A);
    wr(8'h0C, 8'h00);
  endtask

  task automatic t_addr_count();
    logic [7:0] d;
    wr(8'h04, 8'h34); wr(8'h04, 8'h12);
    chk("R3 ch2 addr", cur_addr_o[47:32], 16'h1234);
    chk("R4 ch2 base addr", base_addr_o[47:32], 16'h1234);
    wr(8'h07, 8'hCD); wr(8'h07, 8'hAB);
    chk("R3 ch3 count", cur_cnt_o[63:48], 16'hABCD);
    chk("R4 ch3 base count", base_cnt_o[63:48], 16'hABCD);
    chk("R3 ch3 addr untouched", cur_addr_o[63:48], 16'h0000);
    rd(8'h04, d); chk("R5 addr low", d, 8'h34);
    rd(8'h04, d); chk("R5 addr high", d, 8'h12);
    rd(8'h07, d); chk("R5 count low", d, 8'hCD);
    rd(8'h07, d); chk("R5 count high", d, 8'hAB);
  endtask

  task automatic t_or_merge();
    logic [7:0] d;
    wr(8'h0C, 8'h00);
    wr(8'h00, 8'hAB); wr(8'h00, 8'h0F);
    chk("R4 two-byte load", cur_addr_o[15:0], 16'h0FAB);
    rd(8'h03, d); chk("R2 read flips pointer, low byte", d, 8'h00);
    wr(8'h00, 8'hF0);
    chk("R4 high write ORs", cur_addr_o[15:0], 16'hFFAB);
    chk("R4 base ORs too", base_addr_o[15:0], 16'hFFAB);
    wr(8'h0C, 8'h00);
    wr(8'h00, 8'h21);
    chk("R4 low write replaces", cur_addr_o[15:0], 16'h0021);
    wr(8'h0C, 8'h00);
  endtask

  task automatic t_mode();
    wr(8'h0B, 8'hB7);
    chk("R9 ch3 mode", mode_o[23:18], 6'h2D);
    chk("R9 other modes", mode_o[17:0], 0);
    wr(8'h0B, 8'h48);
    chk("R9 ch0 mode", mode_o[5:0], 6'h12);
  endtask

  task automatic t_page();
    logic [7:0] d;
    wr(8'h87, 8'h11); wr(8'h83, 8'h22); wr(8'h81, 8'h33); wr(8'h82, 8'h44);
    chk("R11 page map", page_o, 32'h44332211);
    rd(8'h81, d); chk("R11 page readback", d, 8'h33);
  endtask

  task automatic t_cmd();
    wr(8'h08, 8'h04);
    chk("R13 command", cmd_o, 8'h04);
  endtask

  task automatic t_mask();
    wr(8'h0E, 8'h00); chk("R8 clear all", mask_o, 4'h0);
    wr(8'h0A, 8'h05); chk("R7 set ch1", mask_o, 4'h2);
    wr(8'h0A, 8'h07); chk("R7 set ch3", mask_o, 4'hA);
    wr(8'h0A, 8'h01); chk("R7 clear ch1", mask_o, 4'h8);
    wr(8'h0F, 8'hF5); chk("R8 write all", mask_o, 4'h5);
  endtask

  task automatic t_status();
    logic [7:0] d;
    pulse(4'b0100, 4'b0000, 4'b0010);
    rd(8'h08, d); chk("R6 status layout", d, 8'h42);
    rd(8'h08, d); chk("R6 tc cleared by read", d, 8'h40);
    @(negedge clk); port_addr = 8'h08; rd_en = 1'b1; tc_set = 4'b0001;
    @(negedge clk); rd_en = 1'b0; tc_set = 4'b0000; d = rd_data;
    chk("R6 read during tc pulse", d, 8'h40);
    rd(8'h08, d); chk("R6 set wins over clear", d, 8'h41);
    rd(8'h08, d); chk("R6 cleared afterwards", d, 8'h40);
    wr(8'h09, 8'h06); rd(8'h08, d); chk("R12 bit2 set no effect", d, 8'h40);
    wr(8'h09, 8'h02); rd(8'h08, d); chk("R12 request cleared", d, 8'h00);
    pulse(4'b1000, 4'b0000, 4'b0000);
    rd(8'h08, d); chk("R6 req_set", d, 8'h80);
    pulse(4'b0000, 4'b1000, 4'b0000);
    rd(8'h08, d); chk("R6 req_clr", d, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    logic [3:0] m; logic [31:0] p; logic [63:0] a; logic [23:0] md;
    m = mask_o; p = page_o; a = cur_addr_o; md = mode_o;
    wr(8'h84, 8'h55); wr(8'h10, 8'hFF); wr(8'h8F, 8'h66); wr(8'h89, 8'h77);
    chk("R14 mask kept", mask_o, m);
    chk("R14 page kept", page_o, p);
    chk("R14 addr kept", cur_addr_o, a);
    chk("R14 mode kept", mode_o, md);
    chk("R14 cmd kept", cmd_o, 8'h04);
    rd(8'h84, d); chk("R14 unmapped read", d, 8'h00);
    rd(8'h0B, d); chk("R14 write-only read", d, 8'h00);
    rd(8'h04, d); chk("R14 pointer untouched", d, 8'h34);
    rd(8'h04, d);
  endtask

  task automatic t_mclr();
    logic [7:0] d;
    wr(8'h0E, 8'h00);
    pulse(4'b0010, 4'b0000, 4'b0001);
    wr(8'h00, 8'h77);
    wr(8'h0D, 8'h00);
    chk("R10 masks set", mask_o, 4'hF);
    chk("R10 cmd cleared", cmd_o, 8'h00);
    chk("R10 modes kept", mode_o[23:18], 6'h2D);
    chk("R10 addr kept", cur_addr_o[15:0], 16'h0077);
    rd(8'h08, d); chk("R10 status cleared", d, 8'h00);
    rd(8'h04, d); chk("R10 pointer cleared", d, 8'h34);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_addr_count();
    t_or_merge();
    t_mode();
    t_page();
    t_cmd();
    t_mask();
    t_status();
    t_unmapped();
    t_mclr();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule